// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a single-channel SPI master driven through a small 16-bit register window. Software programs a control word (enable, master select, clock polarity, clock phase, bit order and a start-mode field), a divider word that sets the serial clock rate, and a chip-select word that drives up to seven select lines. Each write to the transmit register queues one byte. When the controller is enabled in master mode with the start-on-transmit mode selected, the shift engine takes the byte, exchanges eight bits full-duplex on the serial pins, and places the byte it received in the receive register.

Three status flags let software follow a transfer without interrupts. One flag shows that a queued byte is still waiting for the shifter, one shows that the last transfer has completed, and one shows that unread receive data is present. Clearing the control word halts the engine at once and returns the clock to its idle level.

Top module: `spim_top`

## Requirements
- R1: Registers are selected by byte offset: control 0x00, select 0x04, status 0x08, transmit 0x0C, receive 0x10, divider 0x14. Control, select and divider read back what was written, limited to their defined bits. Read data appears on `bus_rdata` on the clock edge that follows the read strobe.
- R2: Control bit 14 enables the block, bit 12 selects master mode and bits 1:0 pick the start mode. A transfer starts only when bits 14 and 12 are both 1, bits 1:0 equal 01, the shifter is idle and a transmit byte is queued. Otherwise a transmit write only queues the byte.
- R3: `sck` idles at control bit 11 (polarity). A transfer makes exactly 16 `sck` edges. The edges are spaced by D system clocks, where D is the divider value, or 2 when the divider is below 2.
- R4: With control bit 10 (phase) at 0, `mosi` holds each bit before the leading edge and `miso` is sampled on the leading edge. With bit 10 at 1, `mosi` changes on the leading edge and `miso` is sampled on the trailing edge.
- R5: With control bit 9 at 1 the byte goes out least-significant bit first; with bit 9 at 0 it goes out most-significant bit first. Received bits are assembled in the same order.
- R6: At the end of a transfer the received byte is stored in the receive register and status bit 5 (receive full) is set. A read of the receive register clears status bit 5.
- R7: Status bit 3 (transmit pending) sets on a transmit write and clears when the shifter takes the byte.
- R8: Status bit 0 (done) is 1 after reset, clears when a transfer starts, and sets on the final `sck` edge.
- R9: For select line n (1..7), select bit n enables the line and bit n+8 gives its level while it is enabled. `cs_n[n-1]` equals that level when the line is enabled and is 1 when it is disabled. Bits 0 and 8 read as 0 and have no effect.
- R10: Writing 0 to the control word during a transfer stops all further `sck` edges, returns `sck` to 0 and leaves status bit 0 clear.
- R11: After reset all registers are 0 except status bit 0, every `cs_n` line is 1, and `sck` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 7 | Select lines 1..7, bit 0 = line 1 |

## Verification
The bench drives all four polarity and phase pairs with both bit orders, and returns either the sent bits or their inverse on `miso`. A wrong sampling edge or a wrong order then shows up as a rotated or reversed byte in the receive register or in the captured `mosi` stream. Divider values of 0 and 1 check the clamp: a design that does not clamp would run too fast or stall. Other tests queue a byte while the block is disabled or in the wrong start mode, where a faulty design would start early. A control clear in mid-transfer checks that the clock stops; a faulty design would finish the byte or leave `sck` high. The select tests write the ignored bits 0 and 8, where a faulty decode would drive a line.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int ADDR_W = 5;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    SEL_CTL  = 3'd0,
    SEL_CS   = 3'd1,
    SEL_STAT = 3'd2,
    SEL_TX   = 3'd3,
    SEL_RX   = 3'd4,
    SEL_DIV  = 3'd5
  } reg_sel_e;

  // control word bit positions
  localparam int C_ENA  = 14;
  localparam int C_MAST = 12;
  localparam int C_POL  = 11;
  localparam int C_PHA  = 10;
  localparam int C_LSB  = 9;
  localparam logic [1:0] START_ON_TX = 2'b01;
  localparam logic [WORD_W-1:0] CTL_MASK =
    WORD_W'((1 << C_ENA) | (1 << C_MAST) | (1 << C_POL) | (1 << C_PHA) | (1 << C_LSB) | 3);

  // status word bit positions
  localparam int S_DONE = 0;
  localparam int S_TXP  = 3;
  localparam int S_RXF  = 5;

  // select word: level bits sit this far above the enable bits
  localparam int LVL_OFS = 8;
endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] div,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim  = (div < CNT_W'(2)) ? CNT_W'(2) : div;
  assign tick = run && (cnt_q == lim - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  // R3: two edges can never fall on adjacent cycles (minimum spacing 2)
  p_no_back2back_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               start,
  input  logic               cpol,
  input  logic               cpha,
  input  logic               lsbf,
  input  logic [FRAME_W-1:0] tx_byte,
  input  logic               miso,
  input  logic               tick,
  output logic               busy,
  output logic               done,
  output logic [FRAME_W-1:0] rx_byte,
  output logic               sck,
  output logic               mosi
);
  localparam int EDGES = 2 * FRAME_W;
  localparam int EC_W  = $clog2(EDGES);

  logic               busy_q, sck_q, mosi_q, samp_q;
  logic [FRAME_W-1:0] sh_q;
  logic [EC_W-1:0]    ec_q;
  logic               leading, last;

  function automatic logic out_bit(input logic [FRAME_W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[FRAME_W-1];
  endfunction

  function automatic logic [FRAME_W-1:0] push(input logic [FRAME_W-1:0] v,
                                              input logic lsb, input logic b);
    return lsb ? {b, v[FRAME_W-1:1]} : {v[FRAME_W-2:0], b};
  endfunction

  assign leading = ~ec_q[0];
  assign last    = (ec_q == EC_W'(EDGES - 1));
  assign done    = busy_q && tick && last;
  assign rx_byte = push(sh_q, lsbf, cpha ? miso : samp_q);
  assign busy    = busy_q;
  assign sck     = sck_q;
  assign mosi    = mosi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; sck_q <= 1'b0; mosi_q <= 1'b0;
      samp_q <= 1'b0; sh_q <= '0; ec_q <= '0;
    end else if (!en) begin
      busy_q <= 1'b0; sck_q <= cpol; ec_q <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1; sh_q <= tx_byte; ec_q <= '0; sck_q <= cpol;
      if (!cpha) mosi_q <= out_bit(tx_byte, lsbf);
    end else if (busy_q && tick) begin
      sck_q <= ~sck_q;
      ec_q  <= ec_q + EC_W'(1);
      if (leading) begin
        if (cpha) mosi_q <= out_bit(sh_q, lsbf);
        else      samp_q <= miso;
      end else if (cpha) begin
        sh_q <= push(sh_q, lsbf, miso);
      end else begin
        sh_q   <= push(sh_q, lsbf, samp_q);
        mosi_q <= out_bit(push(sh_q, lsbf, samp_q), lsbf);
      end
      if (last) busy_q <= 1'b0;
    end else if (!busy_q) begin
      sck_q <= cpol;
    end
  end

  // R3: settled idle clock sits at the polarity level
  p_sck_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !$past(busy_q) && $stable(cpol) && $stable(en)) |-> (sck_q == cpol));
  // R4: pins only move on a divider edge while shifting
  p_pins_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && en && !tick) |=> ($stable(sck_q) && $stable(mosi_q)));
endmodule

// File: rtl/spim_csdrv.sv
module spim_csdrv #(
  parameter int NUM_CS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CS-1:0] line_en,
  input  logic [NUM_CS-1:0] line_lvl,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) cs_n[i] <= 1'b1;
      else     cs_n[i] <= line_en[i] ? line_lvl[i] : 1'b1;
    end

    // R9: a disabled line is driven high on the next cycle
    p_cs_off_high_r9: assert property (@(posedge clk) disable iff (rst)
      !line_en[i] |=> cs_n[i]);
  end
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int NUM_CS  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);
  logic [WORD_W-1:0]  ctl_q, div_q;
  logic [NUM_CS-1:0]  cs_en_q, cs_lvl_q;
  logic [FRAME_W-1:0] tdbr_q, rdbr_q, rx_byte;
  logic               done_f_q, txp_q, rxf_q;
  logic               busy, done, tick, en, start;
  logic               wr, rd, wr_tx;
  reg_sel_e           sel;
  logic [WORD_W-1:0]  cs_word, stat_word;
  logic               unused_bits;

  assign sel   = reg_sel_e'(bus_addr[4:2]);
  assign wr    = bus_en && bus_we;
  assign rd    = bus_en && !bus_we;
  assign wr_tx = wr && (sel == SEL_TX);
  assign en    = ctl_q[C_ENA] && ctl_q[C_MAST];
  assign start = en && (ctl_q[1:0] == START_ON_TX) && txp_q && !busy;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[0], bus_wdata[LVL_OFS]};

  always_comb begin
    cs_word = '0;
    cs_word[NUM_CS:1] = cs_en_q;
    cs_word[LVL_OFS+NUM_CS:LVL_OFS+1] = cs_lvl_q;
    stat_word = '0;
    stat_word[S_DONE] = done_f_q;
    stat_word[S_TXP]  = txp_q;
    stat_word[S_RXF]  = rxf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0; div_q <= '0; cs_en_q <= '0; cs_lvl_q <= '0;
      tdbr_q <= '0; rdbr_q <= '0; bus_rdata <= '0;
      done_f_q <= 1'b1; txp_q <= 1'b0; rxf_q <= 1'b0;
    end else begin
      if (wr) begin
        case (sel)
          SEL_CTL: ctl_q <= bus_wdata & CTL_MASK;
          SEL_CS: begin
            cs_en_q  <= bus_wdata[NUM_CS:1];
            cs_lvl_q <= bus_wdata[LVL_OFS+NUM_CS:LVL_OFS+1];
          end
          SEL_TX:  tdbr_q <= bus_wdata[FRAME_W-1:0];
          SEL_DIV: div_q  <= bus_wdata;
          default: ;
        endcase
      end
      if (start) txp_q <= 1'b0;
      if (wr_tx) txp_q <= 1'b1;
      if (start) done_f_q <= 1'b0;
      if (done)  done_f_q <= 1'b1;
      if (rd && sel == SEL_RX) rxf_q <= 1'b0;
      if (done) begin
        rxf_q  <= 1'b1;
        rdbr_q <= rx_byte;
      end
      if (rd) begin
        case (sel)
          SEL_CTL:  bus_rdata <= ctl_q;
          SEL_CS:   bus_rdata <= cs_word;
          SEL_STAT: bus_rdata <= stat_word;
          SEL_TX:   bus_rdata <= WORD_W'(tdbr_q);
          SEL_RX:   bus_rdata <= WORD_W'(rdbr_q);
          SEL_DIV:  bus_rdata <= div_q;
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  spim_baud #(.CNT_W(WORD_W)) u_baud (
    .clk(clk), .rst(rst), .run(busy), .div(div_q), .tick(tick)
  );

  spim_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .en(en), .start(start),
    .cpol(ctl_q[C_POL]), .cpha(ctl_q[C_PHA]), .lsbf(ctl_q[C_LSB]),
    .tx_byte(tdbr_q), .miso(miso), .tick(tick),
    .busy(busy), .done(done), .rx_byte(rx_byte), .sck(sck), .mosi(mosi)
  );

  spim_csdrv #(.NUM_CS(NUM_CS)) u_cs (
    .clk(clk), .rst(rst), .line_en(cs_en_q), .line_lvl(cs_lvl_q), .cs_n(cs_n)
  );

  // R7: taking the byte empties the transmit slot
  p_txp_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (start && !wr_tx) |=> !txp_q);
  // R8: the done flag drops as a transfer starts
  p_done_clear_r8: assert property (@(posedge clk) disable iff (rst)
    start |=> !done_f_q);
  // R6: completion raises receive-full and done together
  p_end_flags_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> (rxf_q && done_f_q));
  // R2: no shifting while the block is disabled
  p_idle_when_off_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> !busy);
endmodule

// File: tb/sim_spim_top.sv
module sim_spim_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sck, mosi, miso;
  logic [6:0]  cs_n;
  logic        inv_miso = 1'b0;

  int checks = 0, errors = 0;

  assign miso = mosi ^ inv_miso;

  always #4 clk = ~clk;

  spim_top u0 (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  // serial monitor
  bit       cur_cpol = 0, cur_cpha = 0;
  logic     prev_sck = 1'b0;
  int       cyc = 0, edge_cnt = 0, last_edge = 0, min_gap = 0, max_gap = 0, cap_n = 0;
  logic [7:0] cap = '0;

  always @(negedge clk) begin
    cyc++;
    if (sck !== prev_sck) begin
      if (edge_cnt > 0) begin
        if (cyc - last_edge < min_gap) min_gap = cyc - last_edge;
        if (cyc - last_edge > max_gap) max_gap = cyc - last_edge;
      end
      last_edge = cyc;
      edge_cnt++;
      if (((sck !== cur_cpol) ? 1'b1 : 1'b0) ^ cur_cpha) begin
        if (cap_n < 8) cap[cap_n] = mosi;
        cap_n++;
      end
    end
    prev_sck = sck;
  end

  task automatic mon_clear();
    edge_cnt = 0; cap_n = 0; cap = '0; min_gap = 1000000; max_gap = 0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_done(output logic [15:0] st);
    for (int n = 0; n < 3000; n++) begin
      rd_reg(5'h08, st);
      if (st[0]) break;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // {cpol, cpha, lsbf, invert miso, divider[15:0], byte[7:0]}
  localparam logic [27:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 16'd4, 8'hA5},
    {1'b0, 1'b1, 1'b0, 1'b1, 16'd3, 8'h3C},
    {1'b1, 1'b0, 1'b1, 1'b0, 16'd2, 8'h81},
    {1'b1, 1'b1, 1'b1, 1'b1, 16'd5, 8'h6E},
    {1'b0, 1'b0, 1'b1, 1'b1, 16'd0, 8'hC3},
    {1'b1, 1'b1, 1'b0, 1'b0, 16'd1, 8'h17}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [15:0] st, d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);

    // R11 / R8: reset state
    rd_reg(5'h08, st); check("R8 status after reset", st, 16'h0001);
    rd_reg(5'h00, d);  check("R11 control after reset", d, 16'h0000);
    check("R11 cs_n after reset", cs_n, 7'h7F);
    check("R11 sck after reset", sck, 1'b0);

    // R1: readback
    wr_reg(5'h14, 16'h1234); rd_reg(5'h14, d); check("R1 divider readback", d, 16'h1234);
    wr_reg(5'h00, 16'hFFFE); rd_reg(5'h00, d); check("R1 control readback masked", d, 16'h5E02);
    wr_reg(5'h00, 16'h0000);

    // R9: select lines
    wr_reg(5'h04, 16'h080E); rd_reg(5'h04, d); check("R9 select readback", d, 16'h080E);
    check("R9 lines 1,2 low, 3 high", cs_n, 7'b1111100);
    wr_reg(5'h04, 16'h0101); rd_reg(5'h04, d); check("R9 bits 0 and 8 ignored readback", d, 16'h0000);
    check("R9 bits 0 and 8 drive nothing", cs_n, 7'h7F);
    wr_reg(5'h04, 16'h0080); @(negedge clk); check("R9 line 7 low", cs_n, 7'b0111111);
    wr_reg(5'h04, 16'h0000);

    // table of transfers: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 6; i++) begin
      logic [27:0] v;
      logic [7:0]  tx, exp_rx, exp_cap;
      int          half;
      v = VEC[i];
      tx = v[7:0];
      half = (v[23:8] < 2) ? 2 : int'(v[23:8]);
      exp_rx = v[24] ? ~tx : tx;
      for (int k = 0; k < 8; k++) exp_cap[k] = v[25] ? tx[k] : tx[7-k];
      cur_cpol = v[27]; cur_cpha = v[26]; inv_miso = v[24];
      wr_reg(5'h14, v[23:8]);
      wr_reg(5'h00, 16'h5001 | (16'(v[27]) << 11) | (16'(v[26]) << 10) | (16'(v[25]) << 9));
      repeat (3) @(negedge clk);
      mon_clear();
      wr_reg(5'h0C, {8'h00, tx});
      wait_done(st);
      check($sformatf("R8 R7 R6 vec%0d status at end", i), st & 16'h0029, 16'h0021);
      rd_reg(5'h10, d);
      check($sformatf("R6 R4 vec%0d received byte", i), d, {8'h00, exp_rx});
      rd_reg(5'h08, st);
      check($sformatf("R6 vec%0d read clears full", i), st[5], 1'b0);
      check($sformatf("R3 vec%0d edge count", i), edge_cnt, 16);
      check($sformatf("R3 vec%0d min spacing", i), min_gap, half);
      check($sformatf("R3 vec%0d max spacing", i), max_gap, half);
      check($sformatf("R3 vec%0d idle level", i), sck, v[27]);
      check($sformatf("R5 R4 vec%0d bits on mosi", i), cap, exp_cap);
    end

    // R2 / R7: queued byte waits until correctly enabled
    cur_cpol = 0; cur_cpha = 0; inv_miso = 1'b0;
    wr_reg(5'h14, 16'd2);
    wr_reg(5'h00, 16'h1001);
    repeat (3) @(negedge clk);
    mon_clear();
    wr_reg(5'h0C, 16'h0055);
    repeat (40) @(negedge clk);
    rd_reg(5'h08, st); check("R7 R2 pending while disabled", st & 16'h0029, 16'h0009);
    wr_reg(5'h00, 16'h5000);
    repeat (40) @(negedge clk);
    rd_reg(5'h08, st); check("R2 wrong start mode holds byte", st & 16'h0029, 16'h0009);
    check("R2 no edges before start", edge_cnt, 0);
    wr_reg(5'h00, 16'h5001);
    wait_done(st);
    check("R7 pending cleared after start", st[3], 1'b0);
    rd_reg(5'h10, d); check("R2 delayed transfer data", d, 16'h0055);

    // R10: stop in mid-transfer
    wr_reg(5'h14, 16'd40);
    mon_clear();
    wr_reg(5'h0C, 16'h0099);
    repeat (100) @(negedge clk);
    wr_reg(5'h00, 16'h0000);
    repeat (4) @(negedge clk);
    begin
      int held;
      held = edge_cnt;
      repeat (200) @(negedge clk);
      check("R10 no edges after stop", edge_cnt, held);
      check("R10 some edges before stop", (held > 0 && held < 16) ? 1 : 0, 1);
    end
    check("R10 sck back to 0", sck, 1'b0);
    rd_reg(5'h08, st); check("R10 done stays clear", st[0], 1'b0);

    finish_run();
  end
endmodule